// File: doc/BRIEF.md
# Saturating Multiply-Accumulate Unit

This execution unit performs signed sum-of-products and clamped arithmetic on 32-bit words. A request presents an operation code and three operands (`opnd_a`, `opnd_b`, `opnd_c`) together with a one-cycle `start`. The unit returns a 32-bit result with a one-cycle `done` strobe. Products come from an iterative multiplier, so `busy` stays high while a request is in flight. A new request is taken only when `busy` is low.

Arithmetic operations form the exact result at double width plus two guard bits. If that value falls outside the signed 32-bit range, the output is pinned to the limit on the side of the true result. The per-operation `sat_hit` bit is then raised, and so is the sticky `sat_flag`. `sat_flag` stays set until it is cleared through `sat_clr`. Register-file access and instruction decode belong to the surrounding pipeline.

Top module: `satmac_unit`

## Requirements
- R1: While `rst` is high and in the first cycle after it falls, `busy`, `done`, `sat_hit` and `sat_flag` are 0 and `result` is 0.
- R2: A `start` seen with `busy` low is accepted, and `busy` is high from the next cycle until `done`. `done` rises one cycle after acceptance for codes 5, 6, 8, 9 and for reserved codes. It rises DATA_W/MUL_STEP+1 cycles after acceptance for codes 0, 1, 2, 3, 4 and 7. A `start` seen while `busy` is high is ignored.
- R3: When the exact value of an arithmetic operation exceeds 2^31-1, `result` is 0x7FFFFFFF. When it is below -2^31, `result` is 0x80000000. In both cases `sat_hit` is 1 alongside `done`; otherwise `sat_hit` is 0.
- R4: Code 0 returns opnd_c + opnd_a*opnd_b, using the full signed 64-bit product.
- R5: Code 1 returns opnd_c plus the upper 32 bits of the signed product opnd_a*opnd_b.
- R6: Code 2 returns opnd_a*opnd_b clamped. Code 3 returns opnd_a*imm clamped. Code 4 returns opnd_c + opnd_a*imm clamped. Here imm is opnd_b[15:0] sign-extended, and opnd_b[31:16] is ignored.
- R7: Code 5 returns opnd_b+opnd_a clamped. Code 6 returns opnd_b-opnd_a clamped.
- R8: Code 7 returns the upper 32 bits of the signed product opnd_a*opnd_b and never raises `sat_hit`.
- R9: Code 8 returns the signed larger of opnd_a and opnd_b, and code 9 returns the signed smaller. Neither raises `sat_hit`.
- R10: `sat_flag` becomes 1 after any `done` with `sat_hit`. It stays 1 until a cycle with `sat_clr` high, after which it is 0. The exception is a `sat_clr` in the same cycle that an overflowing result completes: the flag then stays 1.
- R11: Codes 10 to 15 return 0 with `sat_hit` 0.
- R12: `result` and `sat_hit` keep their values between `done` strobes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Request strobe |
| op | input | 4 | Operation code |
| opnd_a | input | DATA_W | First operand (multiplicand, addend, subtrahend) |
| opnd_b | input | DATA_W | Second operand or immediate in its low IMM_W bits |
| opnd_c | input | DATA_W | Accumulator operand |
| sat_clr | input | 1 | Clears the sticky saturation flag |
| busy | output | 1 | Request in flight |
| done | output | 1 | Result valid strobe |
| result | output | DATA_W | Operation result |
| sat_hit | output | 1 | Last result was clamped |
| sat_flag | output | 1 | Sticky saturation flag |

## Verification
The bench builds the unit with DATA_W=32, IMM_W=16 and MUL_STEP=4. With these values the multiplier runs eight iterations on 4-bit digits, so multi-bit partial products and carries across digit boundaries are exercised. The nine-cycle multiply latency also leaves room to issue a second `start` while the unit is busy. The 32-bit width brings the exact signed corners within reach: the product of the most negative value with itself, and with -1, and accumulations one step past each limit.

// File: rtl/satmac_pkg.sv
package satmac_pkg;

    localparam int OP_W = 4;

    typedef enum logic [OP_W-1:0] {
        OP_MAC  = 4'd0,
        OP_MACH = 4'd1,
        OP_MULS = 4'd2,
        OP_MULI = 4'd3,
        OP_MACI = 4'd4,
        OP_ADDS = 4'd5,
        OP_SUBS = 4'd6,
        OP_MULH = 4'd7,
        OP_MAX  = 4'd8,
        OP_MIN  = 4'd9
    } sm_op_e;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_RUN  = 1'b1
    } sm_state_e;

    typedef struct packed {
        sm_op_e op;
        logic   via_mult;
    } sm_cmd_t;

    function automatic logic uses_mult(sm_op_e o);
        return (o == OP_MAC) || (o == OP_MACH) || (o == OP_MULS) ||
               (o == OP_MULI) || (o == OP_MACI) || (o == OP_MULH);
    endfunction

    function automatic logic uses_imm(sm_op_e o);
        return (o == OP_MULI) || (o == OP_MACI);
    endfunction

endpackage

// File: rtl/satmac_mult.sv
module satmac_mult #(
    parameter int DATA_W = 32,
    parameter int STEP   = 2
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  go,
    input  logic [DATA_W-1:0]     mul_a,
    input  logic [DATA_W-1:0]     mul_b,
    output logic                  mul_done,
    output logic [2*DATA_W-1:0]   product
);
    localparam int ITERS  = DATA_W / STEP;
    localparam int CNT_W  = $clog2(ITERS + 1);
    localparam int PROD_W = 2 * DATA_W;

    logic [PROD_W-1:0] acc;
    logic [PROD_W-1:0] mcand;
    logic [DATA_W-1:0] mplier;
    logic [CNT_W-1:0]  cnt;
    logic              neg;
    logic              running;
    logic              done_q;
    logic [DATA_W-1:0] a_mag;
    logic [DATA_W-1:0] b_mag;
    logic [PROD_W-1:0] partial;

    assign a_mag = mul_a[DATA_W-1] ? (~mul_a + DATA_W'(1)) : mul_a;
    assign b_mag = mul_b[DATA_W-1] ? (~mul_b + DATA_W'(1)) : mul_b;

    generate
        if (STEP == 1) begin : g_bit_serial
            assign partial = mplier[0] ? mcand : '0;
        end else begin : g_digit_serial
            assign partial = mcand * {{(PROD_W-STEP){1'b0}}, mplier[STEP-1:0]};
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) begin
            acc     <= '0;
            mcand   <= '0;
            mplier  <= '0;
            cnt     <= '0;
            neg     <= 1'b0;
            running <= 1'b0;
            done_q  <= 1'b0;
        end else begin
            done_q <= 1'b0;
            if (go) begin
                acc     <= '0;
                mcand   <= {{DATA_W{1'b0}}, a_mag};
                mplier  <= b_mag;
                neg     <= mul_a[DATA_W-1] ^ mul_b[DATA_W-1];
                cnt     <= CNT_W'(ITERS);
                running <= 1'b1;
            end else if (running) begin
                acc    <= acc + partial;
                mcand  <= mcand << STEP;
                mplier <= mplier >> STEP;
                cnt    <= cnt - CNT_W'(1);
                if (cnt == CNT_W'(1)) begin
                    running <= 1'b0;
                    done_q  <= 1'b1;
                end
            end
        end
    end

    assign mul_done = done_q;
    assign product  = neg ? (~acc + PROD_W'(1)) : acc;

endmodule

// File: rtl/satmac_final.sv
module satmac_final
    import satmac_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  sm_op_e                op,
    input  logic [DATA_W-1:0]     fa,
    input  logic [DATA_W-1:0]     fb,
    input  logic [DATA_W-1:0]     fc,
    input  logic [2*DATA_W-1:0]   prod,
    output logic [DATA_W-1:0]     value,
    output logic                  ovf
);
    localparam int PROD_W = 2 * DATA_W;
    localparam int SUM_W  = PROD_W + 2;
    localparam logic signed [SUM_W-1:0] LIM_HI =
        {{(SUM_W-DATA_W+1){1'b0}}, {(DATA_W-1){1'b1}}};
    localparam logic signed [SUM_W-1:0] LIM_LO =
        {{(SUM_W-DATA_W+1){1'b1}}, {(DATA_W-1){1'b0}}};

    logic signed [SUM_W-1:0] a_x, b_x, c_x, p_x, ph_x, exact;
    logic                    arith;
    logic [DATA_W-1:0]       pick;

    assign a_x  = {{(SUM_W-DATA_W){fa[DATA_W-1]}}, fa};
    assign b_x  = {{(SUM_W-DATA_W){fb[DATA_W-1]}}, fb};
    assign c_x  = {{(SUM_W-DATA_W){fc[DATA_W-1]}}, fc};
    assign p_x  = {{(SUM_W-PROD_W){prod[PROD_W-1]}}, prod};
    assign ph_x = {{(SUM_W-DATA_W){prod[PROD_W-1]}}, prod[PROD_W-1:DATA_W]};

    always_comb begin
        exact = '0;
        arith = 1'b0;
        pick  = '0;
        case (op)
            OP_MAC, OP_MACI: begin exact = c_x + p_x;  arith = 1'b1; end
            OP_MACH:         begin exact = c_x + ph_x; arith = 1'b1; end
            OP_MULS, OP_MULI:begin exact = p_x;        arith = 1'b1; end
            OP_MULH:         begin exact = ph_x;       arith = 1'b1; end
            OP_ADDS:         begin exact = b_x + a_x;  arith = 1'b1; end
            OP_SUBS:         begin exact = b_x - a_x;  arith = 1'b1; end
            OP_MAX:          pick = (a_x > b_x) ? fa : fb;
            OP_MIN:          pick = (a_x < b_x) ? fa : fb;
            default:         pick = '0;
        endcase
    end

    always_comb begin
        ovf   = arith && ((exact > LIM_HI) || (exact < LIM_LO));
        value = pick;
        if (arith) begin
            if (ovf)
                value = exact[SUM_W-1] ? LIM_LO[DATA_W-1:0] : LIM_HI[DATA_W-1:0];
            else
                value = exact[DATA_W-1:0];
        end
    end

endmodule

// File: rtl/satmac_unit.sv
module satmac_unit
    import satmac_pkg::*;
#(
    parameter int DATA_W   = 32,
    parameter int IMM_W    = 16,
    parameter int MUL_STEP = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic [3:0]        op,
    input  logic [DATA_W-1:0] opnd_a,
    input  logic [DATA_W-1:0] opnd_b,
    input  logic [DATA_W-1:0] opnd_c,
    input  logic              sat_clr,
    output logic              busy,
    output logic              done,
    output logic [DATA_W-1:0] result,
    output logic              sat_hit,
    output logic              sat_flag
);
    sm_state_e         state;
    sm_cmd_t           cmd_q;
    sm_op_e            op_in;
    logic [DATA_W-1:0] a_q, b_q, c_q;
    logic [DATA_W-1:0] imm_x, mult_b;
    logic [DATA_W-1:0] result_q;
    logic              done_q, hit_q, sat_q;
    logic              accept, finish, mult_go, mult_done;
    logic [2*DATA_W-1:0] prod;
    logic [DATA_W-1:0] fin_val;
    logic              fin_ovf;

    assign op_in   = sm_op_e'(op);
    assign accept  = start && (state == ST_IDLE);
    assign imm_x   = {{(DATA_W-IMM_W){opnd_b[IMM_W-1]}}, opnd_b[IMM_W-1:0]};
    assign mult_b  = uses_imm(op_in) ? imm_x : opnd_b;
    assign mult_go = accept && uses_mult(op_in);
    assign finish  = (state == ST_RUN) && (!cmd_q.via_mult || mult_done);

    satmac_mult #(.DATA_W(DATA_W), .STEP(MUL_STEP)) i_mult (
        .clk      (clk),
        .rst      (rst),
        .go       (mult_go),
        .mul_a    (opnd_a),
        .mul_b    (mult_b),
        .mul_done (mult_done),
        .product  (prod)
    );

    satmac_final #(.DATA_W(DATA_W)) i_final (
        .op    (cmd_q.op),
        .fa    (a_q),
        .fb    (b_q),
        .fc    (c_q),
        .prod  (prod),
        .value (fin_val),
        .ovf   (fin_ovf)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state    <= ST_IDLE;
            cmd_q    <= '0;
            a_q      <= '0;
            b_q      <= '0;
            c_q      <= '0;
            result_q <= '0;
            done_q   <= 1'b0;
            hit_q    <= 1'b0;
            sat_q    <= 1'b0;
        end else begin
            done_q <= finish;
            sat_q  <= (sat_q && !sat_clr) || (finish && fin_ovf);
            if (finish) begin
                result_q <= fin_val;
                hit_q    <= fin_ovf;
                state    <= ST_IDLE;
            end
            if (accept) begin
                cmd_q.op       <= op_in;
                cmd_q.via_mult <= uses_mult(op_in);
                a_q            <= opnd_a;
                b_q            <= opnd_b;
                c_q            <= opnd_c;
                state          <= ST_RUN;
            end
        end
    end

    assign busy     = (state != ST_IDLE);
    assign done     = done_q;
    assign result   = result_q;
    assign sat_hit  = hit_q;
    assign sat_flag = sat_q;

endmodule

// File: rtl/satmac_chk.sv
module satmac_chk #(
    parameter int DATA_W = 32
) (
    input logic              clk,
    input logic              rst,
    input logic              start,
    input logic              sat_clr,
    input logic              busy,
    input logic              done,
    input logic [DATA_W-1:0] result,
    input logic              sat_hit,
    input logic              sat_flag
);
    localparam logic [DATA_W-1:0] POS_LIM = {1'b0, {(DATA_W-1){1'b1}}};
    localparam logic [DATA_W-1:0] NEG_LIM = {1'b1, {(DATA_W-1){1'b0}}};

    AST_START_BUSY: assert property (@(posedge clk) disable iff (rst)
        start && !busy |=> busy); // R2
    AST_DONE_IDLE: assert property (@(posedge clk) disable iff (rst)
        done |-> !busy); // R2
    AST_SAT_LIMIT: assert property (@(posedge clk) disable iff (rst)
        done && sat_hit |-> (result == POS_LIM) || (result == NEG_LIM)); // R3
    AST_HIT_FLAG: assert property (@(posedge clk) disable iff (rst)
        done && sat_hit |-> sat_flag); // R10
    AST_FLAG_RISE: assert property (@(posedge clk) disable iff (rst)
        $rose(sat_flag) |-> done && sat_hit); // R10
    AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (rst)
        sat_flag && !sat_clr |=> sat_flag); // R10
    AST_FLAG_CLEAR: assert property (@(posedge clk) disable iff (rst)
        sat_clr |=> !sat_flag || (done && sat_hit)); // R10
    AST_RESULT_HOLD: assert property (@(posedge clk) disable iff (rst)
        !done |-> $stable(result) && $stable(sat_hit)); // R12

endmodule

bind satmac_unit satmac_chk #(.DATA_W(DATA_W)) i_satmac_chk (
    .clk      (clk),
    .rst      (rst),
    .start    (start),
    .sat_clr  (sat_clr),
    .busy     (busy),
    .done     (done),
    .result   (result),
    .sat_hit  (sat_hit),
    .sat_flag (sat_flag)
);

// File: tb/test_satmac_unit.sv
`timescale 1ns/1ps
module test_satmac_unit;
    localparam int DW    = 32;
    localparam int MSTEP = 4;
    localparam int MUL_LAT = DW / MSTEP + 2;  // negedges from drive to done
    localparam int ALU_LAT = 2;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          start = 1'b0;
    logic [3:0]    op = '0;
    logic [DW-1:0] opnd_a = '0, opnd_b = '0, opnd_c = '0;
    logic          sat_clr = 1'b0;
    logic          busy, done, sat_hit, sat_flag;
    logic [DW-1:0] result;

    int n_chk = 0;
    int n_fail = 0;
    logic exp_sat = 1'b0;

    always #2.5 clk = ~clk;

    satmac_unit #(.DATA_W(DW), .IMM_W(16), .MUL_STEP(MSTEP)) i_satmac_unit (
        .clk(clk), .rst(rst), .start(start), .op(op),
        .opnd_a(opnd_a), .opnd_b(opnd_b), .opnd_c(opnd_c),
        .sat_clr(sat_clr), .busy(busy), .done(done),
        .result(result), .sat_hit(sat_hit), .sat_flag(sat_flag)
    );

    task automatic check(input string req, input string what,
                         input logic [DW-1:0] act, input logic [DW-1:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    function automatic void model(input logic [3:0] o, input logic [31:0] a,
                                  input logic [31:0] b, input logic [31:0] c,
                                  output logic [31:0] r, output logic h);
        logic signed [65:0] ax, bx, cx, ix, e;
        ax = $signed(a);
        bx = $signed(b);
        cx = $signed(c);
        ix = $signed(b[15:0]);
        case (o)
            4'd0: e = cx + ax * bx;
            4'd1: e = cx + ((ax * bx) >>> 32);
            4'd2: e = ax * bx;
            4'd3: e = ax * ix;
            4'd4: e = cx + ax * ix;
            4'd5: e = bx + ax;
            4'd6: e = bx - ax;
            4'd7: e = (ax * bx) >>> 32;
            4'd8: e = (ax > bx) ? ax : bx;
            4'd9: e = (ax < bx) ? ax : bx;
            default: e = '0;
        endcase
        h = 1'b0;
        r = e[31:0];
        if (e > 66'sh7FFFFFFF) begin h = 1'b1; r = 32'h7FFFFFFF; end
        if (e < -66'sh80000000) begin h = 1'b1; r = 32'h80000000; end
    endfunction

    function automatic logic is_mul(input logic [3:0] o);
        return (o <= 4'd4) || (o == 4'd7);
    endfunction

    task automatic do_op(input string req, input logic [3:0] o,
                         input logic [31:0] a, input logic [31:0] b,
                         input logic [31:0] c);
        logic [31:0] er;
        logic eh;
        int cyc;
        model(o, a, b, c, er, eh);
        @(negedge clk);
        start = 1'b1; op = o; opnd_a = a; opnd_b = b; opnd_c = c;
        cyc = 0;
        do begin
            @(negedge clk);
            start = 1'b0;
            cyc++;
        end while (!done && cyc < 60);
        check(req, "result", result, er);
        check(req, "sat_hit", {31'b0, sat_hit}, {31'b0, eh});
        check("R2", "latency", cyc, is_mul(o) ? MUL_LAT : ALU_LAT);
        exp_sat = exp_sat | eh;
        check("R10", "sat_flag", {31'b0, sat_flag}, {31'b0, exp_sat});
    endtask

    task automatic t_reset();
        repeat (3) @(negedge clk);
        check("R1", "busy in reset", {31'b0, busy}, 0);
        rst = 1'b0;
        @(negedge clk);
        check("R1", "busy", {31'b0, busy}, 0);
        check("R1", "done", {31'b0, done}, 0);
        check("R1", "sat_flag", {31'b0, sat_flag}, 0);
        check("R1", "sat_hit", {31'b0, sat_hit}, 0);
        check("R1", "result", result, 0);
    endtask

    task automatic t_busy_ignore();
        int cyc;
        int extra;
        @(negedge clk);
        start = 1'b1; op = 4'd0; opnd_a = 32'd3; opnd_b = 32'd5; opnd_c = 32'd1;
        @(negedge clk);
        check("R2", "busy after accept", {31'b0, busy}, 1);
        op = 4'd5; opnd_a = 32'd100; opnd_b = 32'd100;  // start still high: ignored
        @(negedge clk);
        start = 1'b0;
        cyc = 2;
        while (!done && cyc < 60) begin @(negedge clk); cyc++; end
        check("R2", "first result kept", result, 32'd16);
        check("R2", "busy-start latency", cyc, MUL_LAT);
        extra = 0;
        repeat (4) begin @(negedge clk); if (done) extra++; end
        check("R2", "no second done", extra, 0);
    endtask

    task automatic t_hold();
        logic [31:0] r0;
        r0 = result;
        repeat (5) @(negedge clk);
        check("R12", "result held", result, r0);
        check("R12", "done low", {31'b0, done}, 0);
    endtask

    task automatic t_clear();
        @(negedge clk);
        sat_clr = 1'b1;
        @(negedge clk);
        sat_clr = 1'b0;
        exp_sat = 1'b0;
        check("R10", "cleared", {31'b0, sat_flag}, 0);
    endtask

    task automatic t_clear_collide();
        @(negedge clk);
        start = 1'b1; op = 4'd5; opnd_a = 32'h7FFFFFFF; opnd_b = 32'd1;
        @(negedge clk);
        start = 1'b0; sat_clr = 1'b1;
        @(negedge clk);
        sat_clr = 1'b0;
        check("R10", "collide done", {31'b0, done}, 1);
        check("R10", "set beats clear", {31'b0, sat_flag}, 1);
        exp_sat = 1'b1;
    endtask

    initial begin
        #(200000 * 5);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog expired");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
        $finish;
    end

    initial begin
        t_reset();
        do_op("R4", 4'd0, 32'd1000, 32'd2000, 32'd5);
        do_op("R4", 4'd0, 32'hFFFFFFFD, 32'd7, 32'd100);
        do_op("R5", 4'd1, 32'h40000000, 32'd8, 32'd10);
        do_op("R5", 4'd1, 32'hC0000000, 32'd8, 32'd0);
        do_op("R6", 4'd2, 32'hFFFFFFF9, 32'd6, 32'd0);
        do_op("R6", 4'd3, 32'd100, 32'hABCDFFFE, 32'd0);
        do_op("R6", 4'd4, 32'd3, 32'h12348000, 32'd50);
        do_op("R7", 4'd5, 32'hFFFFFFFB, 32'd3, 32'd0);
        do_op("R7", 4'd6, 32'd3, 32'd10, 32'd0);
        do_op("R8", 4'd7, 32'h80000000, 32'h80000000, 32'd0);
        do_op("R8", 4'd7, 32'hFFFFFFFF, 32'd1, 32'd0);
        do_op("R9", 4'd8, 32'hFFFFFFFF, 32'd1, 32'd0);
        do_op("R9", 4'd9, 32'hFFFFFFFF, 32'd1, 32'd0);
        do_op("R11", 4'd12, 32'h7FFFFFFF, 32'h7FFFFFFF, 32'd0);
        do_op("R11", 4'd15, 32'd9, 32'd9, 32'd9);
        t_hold();
        // overflow corners
        do_op("R3", 4'd0, 32'h00010000, 32'h00010000, 32'd0);
        do_op("R3", 4'd0, 32'hFFFF0000, 32'h00010000, 32'd0);
        do_op("R3", 4'd0, 32'd4, 32'd4, 32'h7FFFFFF0);
        do_op("R3", 4'd1, 32'h40000000, 32'd8, 32'h7FFFFFFF);
        do_op("R3", 4'd2, 32'h80000000, 32'hFFFFFFFF, 32'd0);
        do_op("R3", 4'd3, 32'h80000000, 32'h00000002, 32'd0);
        do_op("R3", 4'd5, 32'd1, 32'h7FFFFFFF, 32'd0);
        do_op("R3", 4'd6, 32'd1, 32'h80000000, 32'd0);
        t_hold();
        do_op("R10", 4'd5, 32'd1, 32'd1, 32'd0);
        t_clear();
        do_op("R10", 4'd6, 32'd1, 32'd2, 32'd0);
        t_clear_collide();
        t_busy_ignore();
        t_clear();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
        $finish;
    end

endmodule